// File: doc/BRIEF.md
# Serial ADC Interface Emulator

This block stands in for the digital side of a 12-bit, single-channel serial converter while a host controller is being tested. A parallel sample word takes the place of the analog input. A falling edge on the active-low convert-start input freezes that word and raises busy. Busy stays high for a programmable number of system clocks. After that, the host reads the result as a 16-bit serial frame, advanced by falling edges of its serial clock. The data line has its own output enable, so a pad can release the line once the frame ends.

The convert-start level at the end of a conversion decides what comes next. If the level is high, the model waits, ready to be read. If it is low, the model powers down, and only a rising edge of convert-start wakes it. Both asynchronous inputs are synchronised into the system clock domain, and every action is taken there. A two-bit status output reports the current state.

Top module: `adc_serial_model`

## Requirements
- R1: After reset, status is 0 (idle), busy is low and the data output enable is low.
- R2: A falling edge of convert-start in idle (0) or ready (2) starts a conversion: busy rises and status becomes 1, and the sample word is captured at that moment, so later changes of the sample input do not reach the frame.
- R3: Busy stays high for exactly CONV_CYCLES system clocks per conversion.
- R4: When a conversion ends with convert-start high, status becomes 2 (ready). When it ends with convert-start low, status becomes 3 (power-down). From power-down, only a rising edge of convert-start leads back to status 0.
- R5: A falling edge of convert-start during a conversion is ignored: the busy length and the captured sample are unchanged.
- R6: The frame is 16 bits. The k-th serial clock falling edge (k = 1..16) enables the data line and presents frame bit k. Bits 1 to 4 are zero, and bits 5 to 16 carry the 12-bit data, most significant bit first.
- R7: With twos_sel = 0 the data bits are the sample unchanged. With twos_sel = 1 the data bits are the sample with its most significant bit inverted, which turns an offset-binary value into two's complement.
- R8: After the 16th falling edge, the last bit stays enabled for HOLD_CYCLES system clocks. Then the output enable drops, and status goes from ready to idle in the same cycle.
- R9: Serial clock edges during a conversion, or before any conversion has finished, are ignored: the output enable stays low and the next frame still begins at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Convert-start, active-low edge, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sample_in | input | 12 | Sample word standing in for the analog value |
| twos_sel | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| sdata_out | output | 1 | Serial data bit (0 while released) |
| sdata_oe | output | 1 | Data line output enable |
| busy | output | 1 | High during a conversion |
| status | output | 2 | 0 idle, 1 converting, 2 ready, 3 power-down |

## Verification
A change on either asynchronous input takes effect at the third rising clock edge after it is driven: two synchroniser flops, then the acting register. So busy, status and each new frame bit are due three clocks after their stimulus. The end of busy is due CONV_CYCLES clocks after busy rises, and the release of the data line is due HOLD_CYCLES clocks after the 16th falling edge takes effect. Every bench check drives on a falling clock edge and counts exactly that many falling edges before it samples. It also samples one clock before each boundary, to show that the output has not moved early.

// File: rtl/adc_model_pkg.sv
package adc_model_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2,
    ST_PDOWN = 2'd3
  } adc_state_e;
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_async,
  output logic level,
  output logic chg
);
  logic meta;
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= INIT;
      level <= INIT;
      prev  <= INIT;
    end else begin
      meta  <= in_async;
      level <= meta;
      prev  <= level;
    end
  end

  // level differs from its previous sample: one-cycle change event
  assign chg = prev ^ level;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_model_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_level,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       frame_done,
  output adc_state_e state,
  output logic       start_evt,
  output logic       end_evt
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] remain;

  assign start_evt = cs_fall && (state == ST_IDLE || state == ST_READY);
  assign end_evt   = (state == ST_CONV) && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_READY: begin
          if (start_evt) begin
            state  <= ST_CONV;
            remain <= CW'(CONV_CYCLES - 1);
          end else if (state == ST_READY && frame_done) begin
            state <= ST_IDLE;
          end
        end
        ST_CONV: begin
          if (end_evt) state <= cs_level ? ST_READY : ST_PDOWN;
          else         remain <= remain - 1'b1;
        end
        ST_PDOWN: begin
          if (cs_rise) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 4,
  parameter int HOLD_CYCLES = 4,
  localparam int FRAME_W    = LEAD_ZEROS + DATA_W,
  localparam int EW         = $clog2(FRAME_W + 1),
  localparam int HW         = $clog2(HOLD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] sample,
  input  logic              twos_sel,
  input  logic              arm,
  input  logic              sclk_fall,
  input  logic              busy,
  output logic              sdata,
  output logic              oe,
  output logic [EW-1:0]     edges,
  output logic              frame_done
);
  logic [DATA_W-1:0] word;
  logic [HW-1:0]     hold_cnt;
  logic              armed;

  function automatic logic [DATA_W-1:0] encode(input logic [DATA_W-1:0] s, input logic twos);
    encode = s;
    if (twos) encode[DATA_W-1] = ~s[DATA_W-1];
  endfunction

  // idx is 0-based frame position; leading zeros first, then data MSB first
  function automatic logic frame_bit(input logic [DATA_W-1:0] w, input int idx);
    logic [DATA_W-1:0] sh;
    if (idx < LEAD_ZEROS || idx >= FRAME_W) return 1'b0;
    sh = w >> (DATA_W - 1 - (idx - LEAD_ZEROS));
    return sh[0];
  endfunction

  assign frame_done = armed && (edges == EW'(FRAME_W)) &&
                      (hold_cnt == HW'(HOLD_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      armed    <= 1'b0;
      edges    <= '0;
      hold_cnt <= '0;
      oe       <= 1'b0;
    end else if (load) begin
      word     <= encode(sample, twos_sel);
      armed    <= 1'b0;
      edges    <= '0;
      hold_cnt <= '0;
      oe       <= 1'b0;
    end else if (arm) begin
      armed    <= 1'b1;
      edges    <= '0;
      hold_cnt <= '0;
    end else if (armed) begin
      if (edges != EW'(FRAME_W)) begin
        if (sclk_fall && !busy) begin
          edges <= edges + 1'b1;
          oe    <= 1'b1;
        end
      end else if (frame_done) begin
        oe    <= 1'b0;
        armed <= 1'b0;
        edges <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign sdata = oe ? frame_bit(word, int'(edges) - 1) : 1'b0;
endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model
  import adc_model_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 4,
  parameter int CONV_CYCLES = 20,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              twos_sel,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              busy,
  output logic [1:0]        status
);
  localparam int FRAME_W = LEAD_ZEROS + DATA_W;
  localparam int EW      = $clog2(FRAME_W + 1);

  logic       cs_level, cs_chg, cs_fall, cs_rise;
  logic       sclk_level, sclk_chg, sclk_fall;
  logic       conv_start_evt, conv_end_evt, frame_done;
  logic [EW-1:0] frame_edges;
  adc_state_e state;

  adc_sync_edge #(.INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .in_async(conv_start_n),
    .level(cs_level), .chg(cs_chg)
  );

  adc_sync_edge #(.INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .in_async(sclk),
    .level(sclk_level), .chg(sclk_chg)
  );

  assign cs_fall   = cs_chg & ~cs_level;
  assign cs_rise   = cs_chg & cs_level;
  assign sclk_fall = sclk_chg & ~sclk_level;

  adc_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_level(cs_level), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .frame_done(frame_done),
    .state(state), .start_evt(conv_start_evt), .end_evt(conv_end_evt)
  );

  assign busy   = (state == ST_CONV);
  assign status = state;

  adc_frame_shifter #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(conv_start_evt), .sample(sample_in), .twos_sel(twos_sel),
    .arm(conv_end_evt), .sclk_fall(sclk_fall), .busy(busy),
    .sdata(sdata_out), .oe(sdata_oe), .edges(frame_edges),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/adc_model_chk.sv
module adc_model_chk #(
  parameter int CONV_CYCLES = 20,
  parameter int LEAD_ZEROS  = 4,
  parameter int EW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [1:0]    status,
  input logic          sdata_out,
  input logic          sdata_oe,
  input logic [EW-1:0] frame_edges
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == CONV_CYCLES);

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sdata_oe);

  assert_lead_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && frame_edges != '0 && int'(frame_edges) <= LEAD_ZEROS) |-> !sdata_out);

  assert_edge_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edges != $past(frame_edges)) |->
      (frame_edges == $past(frame_edges) + 1'b1 || frame_edges == '0));

  assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(status) == 2'd0 || $past(status) == 2'd2));

  assert_wake_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |=> (status == 2'd3 || status == 2'd0));
endmodule

bind adc_serial_model adc_model_chk #(
  .CONV_CYCLES(CONV_CYCLES), .LEAD_ZEROS(LEAD_ZEROS), .EW(EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .status(status),
  .sdata_out(sdata_out), .sdata_oe(sdata_oe), .frame_edges(frame_edges)
);

// File: tb/adc_serial_model_bench.sv
module adc_serial_model_bench;
  localparam int C = 20;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start_n = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sample_in = '0;
  logic twos_sel = 1'b0;
  logic sdata_out, sdata_oe, busy;
  logic [1:0] status;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_serial_model #(.CONV_CYCLES(C), .HOLD_CYCLES(H)) u_adc_serial_model (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .sclk(sclk),
    .sample_in(sample_in), .twos_sel(twos_sel), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .busy(busy), .status(status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_of(input logic [11:0] s, input logic tw);
    logic [11:0] d;
    d = tw ? (s ^ 12'h800) : s;
    return {4'b0000, d};
  endfunction

  // serial clock pulse; returns three clocks after the falling edge is driven
  task automatic sclk_pulse();
    sclk = 1'b1; tick(3);
    sclk = 1'b0; tick(3);
  endtask

  task automatic read_frame(input logic [15:0] exp, input int end_status, input string req);
    for (int k = 1; k <= 16; k++) begin
      sclk_pulse();
      check("R6", "oe during frame", sdata_oe, 1);
      check(req, $sformatf("frame bit %0d", k), sdata_out, exp[16-k]);
    end
    tick(H - 1);
    check("R8", "oe in hold", sdata_oe, 1);
    check("R8", "last bit held", sdata_out, exp[0]);
    tick(1);
    check("R8", "oe released", sdata_oe, 0);
    check("R8", "status after frame", status, end_status);
  endtask

  task automatic t_reset();
    check("R1", "status", status, 0);
    check("R1", "busy", busy, 0);
    check("R1", "oe", sdata_oe, 0);
    sclk_pulse();
    check("R9", "oe before any conversion", sdata_oe, 0);
  endtask

  // conversion ending with convert-start high, then full read
  task automatic t_convert_read(input logic [11:0] s, input logic tw);
    sample_in = s; twos_sel = tw;
    conv_start_n = 1'b0;
    tick(2);
    check("R2", "busy not yet", busy, 0);
    tick(1);
    check("R2", "busy raised", busy, 1);
    check("R2", "status converting", status, 1);
    sample_in = ~s;
    conv_start_n = 1'b1;
    tick(C - 1);
    check("R3", "busy last cycle", busy, 1);
    tick(1);
    check("R3", "busy ended", busy, 0);
    check("R4", "status ready", status, 2);
    read_frame(frame_of(s, tw), 0, tw ? "R7" : "R6");
  endtask

  task automatic t_power_down();
    sample_in = 12'h3C5; twos_sel = 1'b0;
    conv_start_n = 1'b0;
    tick(3 + C);
    check("R4", "busy ended low cs", busy, 0);
    check("R4", "status power-down", status, 3);
    tick(5);
    check("R4", "stays powered down", status, 3);
    conv_start_n = 1'b1;
    tick(2);
    check("R4", "not awake yet", status, 3);
    tick(1);
    check("R4", "woken to idle", status, 0);
  endtask

  task automatic t_ignore_fall();
    sample_in = 12'h9A6; twos_sel = 1'b0;
    conv_start_n = 1'b0;
    tick(3);
    conv_start_n = 1'b1;
    tick(3);
    conv_start_n = 1'b0;
    sample_in = 12'h111;
    tick(3);
    tick(C - 7);
    check("R5", "busy unchanged length", busy, 1);
    tick(1);
    check("R5", "busy ended on time", busy, 0);
    check("R4", "power-down after late low", status, 3);
    read_frame(frame_of(12'h9A6, 1'b0), 3, "R5");
    conv_start_n = 1'b1;
    tick(3);
    check("R4", "wake after read", status, 0);
  endtask

  task automatic t_sclk_busy();
    sample_in = 12'h5F0; twos_sel = 1'b1;
    conv_start_n = 1'b0;
    tick(3);
    conv_start_n = 1'b1;
    sclk_pulse();
    sclk_pulse();
    check("R9", "oe low during busy", sdata_oe, 0);
    tick(C + 3 - 15);
    check("R9", "conversion done", status, 2);
    check("R9", "oe still low", sdata_oe, 0);
    read_frame(frame_of(12'h5F0, 1'b1), 0, "R9");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_convert_read(12'hA5C, 1'b0);
    t_convert_read(12'hFFF, 1'b0);
    t_convert_read(12'h000, 1'b1);
    t_convert_read(12'h7FF, 1'b1);
    t_power_down();
    t_ignore_fall();
    t_sclk_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule